// File: doc/BRIEF.md
# Serial Priority Interrupt Acknowledge Chain

This block collects interrupt requests from a set of devices and resolves which one the processor serves when it acknowledges. Each device owns one stage. A stage keeps a pending flag that the device sets with a request pulse and that the service routine removes with a clear pulse. All stages share a single active-low request line toward the processor, which is pulled low while any flag is pending.

When the processor raises its acknowledge, the signal enters stage 0, the highest-priority position, and ripples toward the last stage. A stage without a pending flag passes the acknowledge on. A stage with a pending flag stops it and places its own vector address on a shared bus. Stages further down see the acknowledge blocked and stay silent. The vector addresses are a parameter array with one distinct entry per stage. The bus reads zero when no stage drives it.

Top module: `irq_daisy_chain`

## Requirements
- R1: While `rst` is high at a clock edge, every pending flag is cleared, so after that edge `irq_n` is 1 and `vec_bus` is 0.
- R2: A high `dev_req[i]` at a clock edge, with `dev_clr[i]` low, makes stage i pending from the next cycle on.
- R3: A high `dev_clr[i]` at a clock edge makes stage i not pending from the next cycle on, even if `dev_req[i]` is high at the same edge.
- R4: `irq_n` is 0 exactly when at least one stage is pending, and 1 otherwise.
- R5: `cpu_ack` is the priority input of stage 0, and `prio_out[i]` is the priority input of stage i+1. A stage whose priority input is 1 and which is not pending drives `prio_out[i]` = 1.
- R6: A stage whose priority input is 1 and which is pending drives `prio_out[i]` = 0 and puts its own vector on `vec_bus`.
- R7: A stage whose priority input is 0 drives `prio_out[i]` = 0 and puts nothing on the bus, whether pending or not; with `cpu_ack` low all of `prio_out` is 0.
- R8: With `cpu_ack` high, `vec_bus` equals the vector of the lowest-index pending stage; it is 0 when `cpu_ack` is low or no stage is pending. With default parameters stage i's vector is 0x20 + 4*i.
- R9: At most one stage drives the vector bus in any cycle.
- R10: A pending flag keeps its value across cycles in which neither its request nor its clear is high; the acknowledge itself never changes a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_req | input | NUM_STAGES | Per-device request pulse, sets the stage's pending flag |
| dev_clr | input | NUM_STAGES | Per-device clear pulse, clears the pending flag, wins over a request |
| cpu_ack | input | 1 | Processor acknowledge, priority input of stage 0 |
| irq_n | output | 1 | Shared active-low interrupt request |
| prio_out | output | NUM_STAGES | Priority output of each stage, feeding the next stage |
| vec_bus | output | VEC_W | Vector of the granted stage, zero when none is granted |

## Verification
The properties take `dev_req`, `dev_clr` and `cpu_ack` to be synchronous to `clk` and stable around each rising edge, and `cpu_ack` to be a level held for the whole cycle in which the vector is read. The bench changes every input only on the falling edge and holds it through the following rising edge, so each flag update and each chain resolution is seen once. Random request and clear patterns are mixed with acknowledge high and low, with clears kept sparse so that several stages are often pending together and the lowest-index winner is exercised.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

    localparam int DEF_STAGES = 8;
    localparam int DEF_VEC_W  = 8;

    typedef enum logic [1:0] {
        ROLE_BLOCKED = 2'd0,
        ROLE_PASS    = 2'd1,
        ROLE_GRANT   = 2'd2
    } stage_role_e;

    typedef struct packed {
        logic prio_o;
        logic grant;
    } stage_out_t;

    function automatic logic [DEF_STAGES-1:0][DEF_VEC_W-1:0] default_vectors();
        logic [DEF_STAGES-1:0][DEF_VEC_W-1:0] t;
        for (int i = 0; i < DEF_STAGES; i++) begin
            t[i] = DEF_VEC_W'(8'h20 + 4 * i);
        end
        return t;
    endfunction

endpackage

// File: rtl/irq_req_ff.sv
module irq_req_ff (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_o <= 1'b0;
        end else if (clr_i) begin
            pend_o <= 1'b0;
        end else if (set_i) begin
            pend_o <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_prio_stage.sv
module irq_prio_stage
    import irq_chain_pkg::*;
(
    input  logic       prio_i,
    input  logic       pend_i,
    output stage_out_t out_o
);
    stage_role_e role;

    always_comb begin
        if (!prio_i) begin
            role = ROLE_BLOCKED;
        end else if (pend_i) begin
            role = ROLE_GRANT;
        end else begin
            role = ROLE_PASS;
        end
    end

    always_comb begin
        out_o.prio_o = (role == ROLE_PASS);
        out_o.grant  = (role == ROLE_GRANT);
    end
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
    parameter int NUM_STAGES = 8,
    parameter int VEC_W      = 8,
    parameter logic [NUM_STAGES-1:0][VEC_W-1:0] VEC_TABLE = '0
) (
    input  logic [NUM_STAGES-1:0] grant_i,
    output logic [VEC_W-1:0]      bus_o
);
    always_comb begin
        bus_o = '0;
        for (int i = 0; i < NUM_STAGES; i++) begin
            if (grant_i[i]) begin
                bus_o = bus_o | VEC_TABLE[i];
            end
        end
    end
endmodule

// File: rtl/irq_daisy_chain.sv
module irq_daisy_chain
    import irq_chain_pkg::*;
#(
    parameter int NUM_STAGES = DEF_STAGES,
    parameter int VEC_W      = DEF_VEC_W,
    parameter logic [NUM_STAGES-1:0][VEC_W-1:0] VEC_TABLE = default_vectors()
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STAGES-1:0] dev_req,
    input  logic [NUM_STAGES-1:0] dev_clr,
    input  logic                  cpu_ack,
    output logic                  irq_n,
    output logic [NUM_STAGES-1:0] prio_out,
    output logic [VEC_W-1:0]      vec_bus
);
    logic [NUM_STAGES:0]   prio_chain;
    logic [NUM_STAGES-1:0] pend;
    logic [NUM_STAGES-1:0] grant;

    assign prio_chain[0] = cpu_ack;

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        stage_out_t so;

        irq_req_ff u_ff (
            .clk    (clk),
            .rst    (rst),
            .set_i  (dev_req[g]),
            .clr_i  (dev_clr[g]),
            .pend_o (pend[g])
        );

        irq_prio_stage u_stage (
            .prio_i (prio_chain[g]),
            .pend_i (pend[g]),
            .out_o  (so)
        );

        assign prio_chain[g+1] = so.prio_o;
        assign grant[g]        = so.grant;
    end

    assign prio_out = prio_chain[NUM_STAGES:1];
    assign irq_n    = ~(|pend);

    irq_vec_mux #(
        .NUM_STAGES (NUM_STAGES),
        .VEC_W      (VEC_W),
        .VEC_TABLE  (VEC_TABLE)
    ) u_mux (
        .grant_i (grant),
        .bus_o   (vec_bus)
    );
endmodule

// File: rtl/irq_daisy_chain_chk.sv
module irq_daisy_chain_chk #(
    parameter int NUM_STAGES = 8,
    parameter int VEC_W      = 8
) (
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_STAGES-1:0] dev_req,
    input logic [NUM_STAGES-1:0] dev_clr,
    input logic                  cpu_ack,
    input logic                  irq_n,
    input logic [NUM_STAGES-1:0] prio_out,
    input logic [VEC_W-1:0]      vec_bus,
    input logic [NUM_STAGES-1:0] pend,
    input logic [NUM_STAGES-1:0] grant
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (irq_n && vec_bus == '0));

    p_set_takes_r2: assert property (@(posedge clk) disable iff (rst)
        |(dev_req & ~dev_clr) |=>
            ((pend & $past(dev_req & ~dev_clr)) == $past(dev_req & ~dev_clr)));

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (rst)
        |dev_clr |=> ((pend & $past(dev_clr)) == '0));

    p_line_level_r4: assert property (@(posedge clk) disable iff (rst)
        irq_n == (pend == '0));

    p_blocked_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !cpu_ack |-> (prio_out == '0 && grant == '0));

    p_idle_bus_r8: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ack || pend == '0) |-> vec_bus == '0);

    p_single_driver_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    p_grant_stops_r6: assert property (@(posedge clk) disable iff (rst)
        (grant != '0) |-> ((prio_out & ~((grant - 1'b1) | grant)) == '0));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (dev_req == '0 && dev_clr == '0) |=> pend == $past(pend));
endmodule

bind irq_daisy_chain irq_daisy_chain_chk #(
    .NUM_STAGES (NUM_STAGES),
    .VEC_W      (VEC_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .dev_req  (dev_req),
    .dev_clr  (dev_clr),
    .cpu_ack  (cpu_ack),
    .irq_n    (irq_n),
    .prio_out (prio_out),
    .vec_bus  (vec_bus),
    .pend     (pend),
    .grant    (grant)
);

// File: tb/test_irq_daisy_chain.sv
`timescale 1ns/1ps
module test_irq_daisy_chain;
    localparam int N = 8;
    localparam int W = 8;

    typedef struct {
        logic         irq_n;
        logic [N-1:0] po;
        logic [W-1:0] vec;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] dev_req = '0;
    logic [N-1:0] dev_clr = '0;
    logic         cpu_ack = 1'b0;
    logic         irq_n;
    logic [N-1:0] prio_out;
    logic [W-1:0] vec_bus;

    exp_t         sb[$];
    logic [N-1:0] mpend = '0;
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    irq_daisy_chain i_irq_daisy_chain (
        .clk      (clk),
        .rst      (rst),
        .dev_req  (dev_req),
        .dev_clr  (dev_clr),
        .cpu_ack  (cpu_ack),
        .irq_n    (irq_n),
        .prio_out (prio_out),
        .vec_bus  (vec_bus)
    );

    // Driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input logic r, input logic [N-1:0] rq,
                        input logic [N-1:0] cl, input logic ak, input string tag);
        exp_t e;
        logic pi;
        @(negedge clk);
        rst = r; dev_req = rq; dev_clr = cl; cpu_ack = ak;
        if (r) mpend = '0;
        else   mpend = (mpend | rq) & ~cl;
        e.irq_n = (mpend == '0);
        e.po    = '0;
        e.vec   = '0;
        e.tag   = tag;
        pi = ak;
        for (int i = 0; i < N; i++) begin
            if (pi && mpend[i]) e.vec = W'(8'h20 + 4 * i);
            e.po[i] = pi && !mpend[i];
            pi = e.po[i];
        end
        sb.push_back(e);
    endtask

    // Monitor: samples mid-cycle after each rising edge
    always @(posedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            #5;
            e = sb.pop_front();
            n_chk++;
            if (irq_n !== e.irq_n) begin
                n_fail++;
                $display("FAIL %s irq_n actual=%b expected=%b", e.tag, irq_n, e.irq_n);
            end
            n_chk++;
            if (prio_out !== e.po) begin
                n_fail++;
                $display("FAIL %s prio_out actual=%b expected=%b", e.tag, prio_out, e.po);
            end
            n_chk++;
            if (vec_bus !== e.vec) begin
                n_fail++;
                $display("FAIL %s vec_bus actual=%h expected=%h", e.tag, vec_bus, e.vec);
            end
        end
    end

    initial begin
        #4_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(1, '0, '0, 0, "R1 reset");
        step(1, '1, '0, 1, "R1 reset with requests");
        step(0, '0, '0, 0, "R1 R4 idle after reset");
        step(0, 8'h08, '0, 0, "R2 R4 R7 set stage3 no ack");
        step(0, '0, '0, 1, "R5 R6 R8 ack grants stage3");
        step(0, '0, '0, 1, "R10 ack keeps flag");
        step(0, 8'h02, 8'h02, 1, "R3 clear wins over set");
        step(0, '0, 8'h08, 1, "R3 R5 R8 clear stage3 all pass");
        step(0, 8'h80, '0, 1, "R6 R8 last stage only");
        step(0, 8'hFF, '0, 1, "R6 R7 R8 all pending stage0 wins");
        step(0, '0, 8'h01, 1, "R8 next lowest stage1 wins");
        step(0, '0, '0, 0, "R7 ack low blocks chain");
        step(0, '0, 8'h7F, 1, "R3 R8 only stage7 left");
        for (int k = 0; k < 600; k++) begin
            logic [N-1:0] rq, cl;
            rq = N'($urandom) & N'($urandom);
            cl = N'($urandom) & N'($urandom) & N'($urandom);
            step(0, rq, cl, 1'($urandom % 4 != 0), "R8 R9 random lowest pending wins");
        end
        step(1, '0, '0, 1, "R1 reset mid run");
        step(0, '0, '0, 1, "R4 R8 empty after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule